// File: doc/BRIEF.md
# Quad SPI PIO Transfer Sequencer

This block is the serial engine of a half-duplex flash master. It runs one transfer segment at a time. Before a segment starts, software sets up a configuration word and a chip-select choice. The configuration word holds the direction, the lane width and a fragment flag. Writing a nonzero byte count then starts the segment.

While the segment runs, the block generates the serial clock from the core clock at one quarter of the core rate. It drives one of two active-low chip selects. It shifts each byte out on 1, 2 or 4 data lines, or samples each byte in from them. Transmit bytes come from an external transmit FIFO and received bytes go to an external receive FIFO.

The fragment flag controls what happens at the end of a segment. When the flag is set, the device stays selected, so that a command, an address and a data phase can be issued as separate segments of one device transaction. A segment with the flag clear releases chip select when it ends. At the end of every segment a sticky done flag is raised.

Top module: `qspi_pio_seq`

## Requirements
- R1: After reset both chip selects are high, the serial clock is low, and busy and done are low. Lines 2 and 3 are driven high and lines 0 and 1 are not driven.
- R2: A pulse on `start_wr` starts a segment of `start_cnt` bytes only when the block is idle and the count is nonzero. A zero count has no effect, and so does a pulse while busy.
- R3: `xfer_cfg[3:1]` selects the lanes. Code 2 selects two lines, sending or receiving bit pairs most significant pair first on lines 1:0. Code 3 selects four lines, high nibble first on lines 3:0. Every other code selects one line: transmit on line 0, receive sampled on line 1, most significant bit first.
- R4: `xfer_cfg[0]` = 1 makes a write segment: bytes are popped from the transmit FIFO and the data lanes are driven. `xfer_cfg[0]` = 0 makes a read segment: bytes are pushed into the receive FIFO and the data lanes are not driven.
- R5: The serial clock idles low. Each period is four core cycles, two low followed by two high. Transmit data changes only while the clock is low, and receive data is taken at the rising edge.
- R6: `cs_pick` = 0 selects `cs_n[0]` and `cs_pick` = 1 selects `cs_n[1]`. The two chip selects are never low together.
- R7: When no device is already selected, chip select falls one core cycle before the first rising clock edge. A final segment releases it four core cycles after the last falling clock edge.
- R8: When `xfer_cfg[8]` is set, chip select stays low after the segment ends and remains low into the next segment.
- R9: While the transmit FIFO is empty during a write, the clock is held low and chip select holds its level. Nothing is popped.
- R10: While the receive FIFO is full at a byte boundary of a read, the clock is held low and chip select holds its level. Nothing is pushed.
- R11: `done` rises in the cycle the segment ends, with busy already low. It stays high until the next segment starts.
- R12: Lines 2 and 3 are driven high at all times except while a four-line segment is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_cfg | input | 9 | Segment setup: bit 0 direction, bits 3:1 lane code, bit 8 fragment |
| cs_pick | input | 1 | Which chip select the segment uses |
| start_wr | input | 1 | Count write strobe; starts a segment |
| start_cnt | input | CNT_W | Byte count of the segment |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO has no byte |
| tx_pop | output | 1 | Take the head byte of the transmit FIFO |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| rx_full | input | 1 | Receive FIFO has no room |
| sclk | output | 1 | Serial clock |
| cs_n | output | 2 | Active-low chip selects |
| io_out | output | 4 | Output values of data lines 3:0 |
| io_oe | output | 4 | Output enables of data lines 3:0 |
| io_in | input | 4 | Input values of data lines 3:0 |
| busy | output | 1 | A segment is in progress |
| done | output | 1 | Sticky end-of-segment flag |

## Verification
Each kind of internal fault shows up at the ports within a bounded time:
- A wrong phase count shows on `sclk` within one serial period.
- A wrong beat count or lane shift corrupts the first byte on `io_out`, or the first value on `rx_data`.
- A wrong byte count moves the fall of `busy` and the rise of `done` by four or more core cycles per byte.
- A chip-select state that is not updated or not held shows on `cs_n` at the first stall, or at the end of a fragment segment.

The reference model sees random line values on every core cycle. Sampling on the wrong edge therefore corrupts received bytes at once.

// File: rtl/qspi_pio_seq.sv
module qspi_pio_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [8:0]       xfer_cfg,
  input  logic             cs_pick,
  input  logic             start_wr,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic [7:0]       tx_data,
  input  logic             tx_empty,
  output logic             tx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_push,
  input  logic             rx_full,
  output logic             sclk,
  output logic [1:0]       cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in,
  output logic             busy,
  output logic             done
);

  localparam int DIR_BIT  = 0;
  localparam int FRAG_BIT = 8;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN, S_TAIL} st_t;

  st_t              st;
  logic [1:0]       ph;
  logic [2:0]       beat;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh;
  logic             cs_act, sel, wr, frag, sclk_r, done_r;
  logic [1:0]       lsh, lsh_new;
  logic [3:0]       rx_bits, tx_bits;

  always_comb begin
    case (xfer_cfg[3:1])
      3'd2:    lsh_new = 2'd1;
      3'd3:    lsh_new = 2'd2;
      default: lsh_new = 2'd0;
    endcase
  end

  always_comb begin
    case (lsh)
      2'd1:    begin rx_bits = {2'b00, io_in[1:0]}; tx_bits = {2'b00, sh[7:6]}; end
      2'd2:    begin rx_bits = io_in;               tx_bits = sh[7:4];          end
      default: begin rx_bits = {3'b000, io_in[1]};  tx_bits = {3'b000, sh[7]};  end
    endcase
  end

  wire       go        = (st == S_IDLE) && start_wr && (start_cnt != '0);
  wire       ok        = wr ? !tx_empty : !rx_full;
  wire       last_beat = (beat == (3'd7 >> lsh));
  wire [3:0] step      = 4'd1 << lsh;
  wire       quad      = busy && (lsh == 2'd2);
  wire       run_wr    = (st == S_RUN) && wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; beat <= '0; cnt <= '0; sh <= '0;
      cs_act <= 1'b0; sel <= 1'b0; wr <= 1'b0; frag <= 1'b0;
      lsh <= '0; sclk_r <= 1'b0; done_r <= 1'b0;
    end else begin
      sclk_r <= (st == S_RUN) && (ph == 2'd1 || ph == 2'd2);
      case (st)
        S_IDLE: if (go) begin
          st     <= S_FETCH;
          cnt    <= start_cnt;
          wr     <= xfer_cfg[DIR_BIT];
          frag   <= xfer_cfg[FRAG_BIT];
          lsh    <= lsh_new;
          sel    <= cs_pick;
          done_r <= 1'b0;
        end
        S_FETCH: if (ok) begin
          cs_act <= 1'b1;
          ph     <= 2'd1;
          beat   <= '0;
          if (wr) sh <= tx_data;
          st     <= S_RUN;
        end
        S_RUN: begin
          ph <= ph + 2'd1;
          if (ph == 2'd1 && !wr) sh <= (sh << step) | {4'b0000, rx_bits};
          if (ph == 2'd3) begin
            if (last_beat) begin
              cnt <= cnt - 1'b1;
              st  <= (cnt == CNT_W'(1)) ? S_TAIL : S_FETCH;
            end else begin
              beat <= beat + 3'd1;
              if (wr) sh <= sh << step;
            end
          end
        end
        S_TAIL: begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) begin
            cs_act <= frag;
            done_r <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = done_r;
  assign sclk    = sclk_r;
  assign cs_n    = cs_act ? (sel ? 2'b01 : 2'b10) : 2'b11;
  assign tx_pop  = (st == S_FETCH) && wr && !tx_empty;
  assign rx_push = (st == S_RUN) && !wr && (ph == 2'd3) && last_beat;
  assign rx_data = sh;

  assign io_oe[1:0]  = (busy && wr) ? ((lsh == 2'd0) ? 2'b01 : 2'b11) : 2'b00;
  assign io_oe[3:2]  = quad ? {2{wr}} : 2'b11;
  assign io_out[1:0] = run_wr ? tx_bits[1:0] : 2'b00;
  assign io_out[3:2] = quad ? (run_wr ? tx_bits[3:2] : 2'b00) : 2'b11;

  a_r6_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r9_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);
  a_r10_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
  a_r5_high_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> (sclk ##1 !sclk));
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && !ok) |=> ($stable(cs_n) && !sclk));
  a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);

endmodule

// File: tb/tb_qspi_pio_seq.sv
module tb_qspi_pio_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0]  xfer_cfg = '0;
  logic        cs_pick = 1'b0;
  logic        start_wr = 1'b0;
  logic [15:0] start_cnt = '0;
  logic [7:0]  tx_data = '0;
  logic        tx_empty = 1'b1;
  logic        tx_pop;
  logic [7:0]  rx_data;
  logic        rx_push;
  logic        rx_full = 1'b0;
  logic        sclk;
  logic [1:0]  cs_n;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = '0;
  logic        busy, done;

  always #5 clk = ~clk;

  qspi_pio_seq dut (
    .clk(clk), .rst_n(rst_n), .xfer_cfg(xfer_cfg), .cs_pick(cs_pick),
    .start_wr(start_wr), .start_cnt(start_cnt), .tx_data(tx_data),
    .tx_empty(tx_empty), .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
    .rx_full(rx_full), .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in), .busy(busy), .done(done)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [7:0] tx_q[$];
  logic tx_block = 1'b0;
  logic pop_seen = 1'b0;

  always @(posedge clk) begin
    #1;
    if (pop_seen && tx_q.size() != 0) void'(tx_q.pop_front());
    #1;
    tx_empty = (tx_q.size() == 0) || tx_block;
    tx_data  = (tx_q.size() != 0) ? tx_q[0] : 8'h00;
  end

  always @(posedge clk) begin
    #1;
    io_in = 4'($urandom);
  end

  // behavioural reference model
  logic       m_busy = 0, m_done = 0, m_cs = 0, m_sel = 0, m_wr = 0, m_frag = 0;
  logic       m_fetch = 0, m_run = 0, m_sclk = 0, m_push = 0;
  logic [3:0] m_chunk = 0;
  logic [7:0] m_rxd = 0, m_byte = 0, m_acc = 0;
  int         m_L = 1, m_n = 0, m_beats = 0, m_ph = 0, m_bt = 0;
  bit         m_ok;

  initial begin : model
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      if (start_wr && start_cnt != 0) begin
        m_wr = xfer_cfg[0]; m_frag = xfer_cfg[8]; m_sel = cs_pick;
        m_L = (xfer_cfg[3:1] == 3'd2) ? 2 : (xfer_cfg[3:1] == 3'd3) ? 4 : 1;
        m_n = start_cnt; m_busy = 1; m_done = 0;
        m_beats = 8 / m_L;
        for (int b = 0; b < m_n; b++) begin
          m_fetch = 1; m_run = 0; m_sclk = 0; m_push = 0; m_chunk = 0;
          m_ok = 0;
          while (!m_ok) begin
            @(posedge clk);
            m_ok = m_wr ? !tx_empty : !rx_full;
          end
          m_byte = m_wr ? tx_q[0] : 8'h00;
          m_fetch = 0; m_run = 1; m_cs = 1; m_acc = 0;
          for (int k = 1; k < 4 * m_beats; k++) begin
            m_ph = k % 4; m_bt = k / 4;
            m_sclk = (m_ph >= 2);
            m_chunk = m_wr ? 4'((m_byte >> (8 - m_L * (m_bt + 1))) & ((1 << m_L) - 1)) : 4'h0;
            m_push = !m_wr && (k == 4 * m_beats - 1);
            m_rxd = m_acc;
            @(posedge clk);
            if (!m_wr && m_ph == 1)
              m_acc = (m_acc << m_L) | ((m_L == 1) ? {7'b0, io_in[1]} :
                                        (m_L == 2) ? {6'b0, io_in[1:0]} : {4'b0, io_in});
          end
        end
        m_run = 0; m_sclk = 0; m_push = 0; m_chunk = 0;
        repeat (4) @(posedge clk);
        m_cs = m_frag; m_done = 1; m_busy = 0;
      end
    end
  end

  always @(negedge clk) begin
    logic [1:0] e_cs;
    logic [3:0] e_oe, e_out;
    if (rst_n) begin
      e_cs = m_cs ? (m_sel ? 2'b01 : 2'b10) : 2'b11;
      if (m_busy && m_L == 4) begin
        e_oe[3:2]  = m_wr ? 2'b11 : 2'b00;
        e_out[3:2] = (m_run && m_wr) ? m_chunk[3:2] : 2'b00;
      end else begin
        e_oe[3:2] = 2'b11; e_out[3:2] = 2'b11;
      end
      e_oe[1:0]  = (m_busy && m_wr) ? ((m_L == 1) ? 2'b01 : 2'b11) : 2'b00;
      e_out[1:0] = (m_run && m_wr) ? m_chunk[1:0] : 2'b00;
      chk("R5 sclk", sclk, m_sclk);
      chk("R7 R6 cs_n", cs_n, e_cs);
      chk("R3 io_out", io_out, e_out);
      chk("R4 R12 io_oe", io_oe, e_oe);
      chk("R2 busy", busy, m_busy);
      chk("R11 done", done, m_done);
      chk("R9 tx_pop", tx_pop, m_fetch && m_wr && !tx_empty);
      chk("R10 rx_push", rx_push, m_push);
      if (m_push) chk("R3 rx_data", rx_data, m_rxd);
    end
    pop_seen = tx_pop;
  end

  task automatic start_seg(input bit w, input logic [2:0] mode, input bit frag,
                           input bit cs, input int n);
    @(posedge clk); #1;
    xfer_cfg = {frag, 4'b0000, mode, w}; cs_pick = cs; start_cnt = 16'(n); start_wr = 1;
    @(posedge clk); #1;
    start_wr = 0;
  endtask

  task automatic wait_idle();
    @(posedge clk); #1;
    while (busy) begin @(posedge clk); #1; end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 cs_n", cs_n, 2'b11); chk("R1 sclk", sclk, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 io_oe", io_oe, 4'b1100);

    // zero count is ignored
    start_seg(1, 3'd1, 0, 0, 0);
    repeat (3) @(posedge clk); #1;
    chk("R2 zero count", busy, 0);

    // one line write, cs0, final
    tx_q.push_back(8'hA5); tx_q.push_back(8'h3C); tx_q.push_back(8'hF0);
    start_seg(1, 3'd1, 0, 0, 3);
    repeat (4) @(posedge clk); #1;
    chk("R6 cs0 low", cs_n, 2'b10);
    wait_idle();
    chk("R7 released", cs_n, 2'b11);
    chk("R11 done set", done, 1);

    // two line write, cs1, fragment, transmit stall, start while busy
    tx_q.push_back(8'h96);
    start_seg(1, 3'd2, 1, 1, 4);
    repeat (25) @(posedge clk); #1;
    chk("R9 stall sclk", sclk, 0);
    chk("R9 stall cs", cs_n, 2'b01);
    start_cnt = 16'd9; start_wr = 1;
    @(posedge clk); #1; start_wr = 0;
    tx_q.push_back(8'h5A); tx_q.push_back(8'hC3); tx_q.push_back(8'h0F);
    tx_q.push_back(8'hEE);
    wait_idle();
    chk("R2 busy start ignored", tx_q.size(), 1);
    chk("R8 cs held", cs_n, 2'b01);
    void'(tx_q.pop_front());

    // four line read continuing on cs1, receive stall
    rx_full = 1;
    start_seg(0, 3'd3, 0, 1, 3);
    repeat (12) @(posedge clk); #1;
    chk("R10 stall sclk", sclk, 0);
    chk("R10 stall cs", cs_n, 2'b01);
    chk("R4 read undriven", io_oe, 4'b0000);
    rx_full = 0;
    wait_idle();
    chk("R7 final release", cs_n, 2'b11);
    chk("R12 lines high", io_oe[3:2], 2'b11);

    // one line read
    start_seg(0, 3'd1, 0, 0, 2);
    wait_idle();

    // four line write with transmit stall in the middle
    tx_q.push_back(8'h81); tx_q.push_back(8'h7E);
    start_seg(1, 3'd3, 0, 0, 2);
    repeat (3) @(posedge clk); #1;
    tx_block = 1;
    repeat (14) @(posedge clk); #1;
    tx_block = 0;
    wait_idle();

    // unused code acts as one line
    tx_q.push_back(8'hB4);
    start_seg(1, 3'd6, 0, 1, 1);
    wait_idle();
    chk("R3 fallback byte used", tx_q.size(), 0);

    repeat (3) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule